// File: doc/BRIEF.md
# Byte/Word Status-Flag ALU

This block is the arithmetic and logic stage of a small 16-bit processor core. It has no clock. It takes two operands, an operation code, a size select and the current status flags, and it returns the result, the updated flags and a write strobe. The write strobe tells the register stage whether to store the result. A size select of byte restricts the whole computation to the low eight bits.

The same block also decides conditional branches. It evaluates a three-bit condition code against the incoming flags and drives a single taken/not-taken line, which the sequencer uses without further decoding. Each operation has its own rule for which status bits it may change. Bits outside that set pass through from the flag input unchanged.

Flags are packed as {V, N, Z, C} (bit 3 = overflow, bit 2 = negative, bit 1 = zero, bit 0 = carry). Below, `a` is the first operand (destination and minuend) and `b` is the second operand. W is 8 in byte mode and 16 in word mode.

Top module: `flag_alu`

## Requirements
- R1: With wordMode=0 both operands are cut to bits 7:0 before use, result[15:8] is 0, and N, C and V are taken at bit 7. With wordMode=1 the full 16 bits are used.
- R2: Code 1 (add) gives a+b and code 2 (add with carry) gives a+b+Cin, each kept to W bits. C is the carry out of bit W-1.
- R3: Code 3 (subtract), code 4 (subtract with carry) and code 5 (compare) each compute a + (~b masked to W) + k. k is 1 for codes 3 and 5 and Cin for code 4. C is the carry out of bit W-1, so C=1 means no borrow.
- R4: For codes 1 to 5, V is set exactly when the signed value of the operation (a+b+carry-in, or a-b+k-1) lies outside the signed range of W bits.
- R5: Every operation that updates flags sets N to bit W-1 of the result and Z to 1 when the result is zero.
- R6: Code 6 (decimal add) reads each operand as packed 4-bit decimal digits, adds both values and Cin, and returns the sum as packed decimal digits kept to W bits. C is set when the sum exceeds 99 (byte) or 9999 (word). V is left unchanged.
- R7: Code 7 (AND) and code 8 (bit test) give a&b. Code 11 (XOR) gives a^b. All three set C when the result is non-zero. V is 0 for codes 7 and 8. For code 11, V is 1 when both operands have bit W-1 set.
- R8: Code 12 shifts a right by one with Cin into bit W-1. Code 13 shifts zero in. Code 14 keeps bit W-1. All three put old bit 0 into C and clear V.
- R9: Code 0 (move) gives b, code 9 gives a&~b, code 10 gives a|b, code 15 exchanges the two bytes of a, and code 16 copies bit 7 of a into bits 15:8. None of these five changes any flag.
- R10: writeResult is 1 for every defined code except 5 and 8. Codes 17 to 31 are reserved: they give result 0, writeResult 0 and unchanged flags.
- R11: condTrue follows condSel as follows: 0 when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 5 when N equals V, 6 when N differs from V, and 7 always.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wordMode | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| opSel | input | 5 | Operation code |
| opA | input | 16 | First operand (destination, minuend, shift source) |
| opB | input | 16 | Second operand |
| flagsIn | input | 4 | Current status {V,N,Z,C}; C is the carry-in |
| condSel | input | 3 | Branch condition code |
| result | output | 16 | Operation result |
| flagsOut | output | 4 | Updated status {V,N,Z,C} |
| writeResult | output | 1 | Result should be stored |
| condTrue | output | 1 | Selected branch condition holds |

## Verification
In byte mode, every operation code is run over a dense sweep of first operands against sixteen second operands, with both carry-in values. That sweep catches errors in carry and overflow at the bit-7 boundary, in the fill bit of each shift, and in decimal digits that overflow or are invalid. In word mode, a set of edge values is run, including 0x7FFF, 0x8000, 0xFFFF and 0x9999. Those values separate word carry from byte carry, show signed overflow in both directions, and confirm that the sum limit of 9999 applies in decimal add. A pseudo-random word sweep then covers bit patterns the edge values miss. All sixteen flag combinations are tried under each condition code, which separates the N-versus-V tests from the single-bit tests.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;
  localparam int DATA_W = 16;
  localparam int OP_W   = 5;
  localparam int COND_W = 3;
  localparam int FLAG_W = 4;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;

  typedef enum logic [OP_W-1:0] {
    OP_MOV  = 5'd0,  OP_ADD  = 5'd1,  OP_ADDC = 5'd2,  OP_SUB  = 5'd3,
    OP_SUBC = 5'd4,  OP_CMP  = 5'd5,  OP_DADD = 5'd6,  OP_AND  = 5'd7,
    OP_BIT  = 5'd8,  OP_BIC  = 5'd9,  OP_BIS  = 5'd10, OP_XOR  = 5'd11,
    OP_RRC  = 5'd12, OP_RRU  = 5'd13, OP_RRA  = 5'd14, OP_SWAP = 5'd15,
    OP_SEXT = 5'd16
  } aluOp_e;

  typedef enum logic [3:0] {
    RS_ADD, RS_DEC, RS_AND, RS_BIC, RS_BIS, RS_XOR,
    RS_SHR, RS_PASS, RS_SWAP, RS_SEXT, RS_NONE
  } resSel_e;

  typedef enum logic [1:0] {CI_ZERO, CI_ONE, CI_FLAG} carrySel_e;
  typedef enum logic [1:0] {FILL_CARRY, FILL_ZERO, FILL_SIGN} fillSel_e;
  typedef enum logic [2:0] {CV_ARITH, CV_DEC, CV_LOGIC, CV_XOR, CV_SHIFT} flagRule_e;

  typedef struct packed {
    resSel_e             resSel;
    logic                invB;
    carrySel_e           carrySel;
    fillSel_e            fill;
    flagRule_e           rule;
    logic [FLAG_W-1:0]   flagMask;
    logic                wrEn;
  } aluCtrl_t;
endpackage

// File: rtl/flag_alu_ctrl.sv
module flag_alu_ctrl
  import flag_alu_pkg::*;
(
  input  logic [OP_W-1:0]   opSel,
  input  logic [COND_W-1:0] condSel,
  input  logic [FLAG_W-1:0] flagsIn,
  output aluCtrl_t          ctrl,
  output logic              condTrue
);
  localparam logic [FLAG_W-1:0] MASK_ALL  = 4'b1111;
  localparam logic [FLAG_W-1:0] MASK_NZC  = 4'b0111;
  localparam logic [FLAG_W-1:0] MASK_NONE = 4'b0000;

  always_comb begin
    ctrl = '{resSel: RS_NONE, invB: 1'b0, carrySel: CI_ZERO, fill: FILL_ZERO,
             rule: CV_LOGIC, flagMask: MASK_NONE, wrEn: 1'b0};
    unique case (opSel)
      OP_MOV:  begin ctrl.resSel = RS_PASS; ctrl.wrEn = 1'b1; end
      OP_ADD:  begin ctrl.resSel = RS_ADD; ctrl.rule = CV_ARITH;
                     ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_ADDC: begin ctrl.resSel = RS_ADD; ctrl.rule = CV_ARITH; ctrl.carrySel = CI_FLAG;
                     ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_SUB:  begin ctrl.resSel = RS_ADD; ctrl.rule = CV_ARITH; ctrl.invB = 1'b1;
                     ctrl.carrySel = CI_ONE; ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_SUBC: begin ctrl.resSel = RS_ADD; ctrl.rule = CV_ARITH; ctrl.invB = 1'b1;
                     ctrl.carrySel = CI_FLAG; ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_CMP:  begin ctrl.resSel = RS_ADD; ctrl.rule = CV_ARITH; ctrl.invB = 1'b1;
                     ctrl.carrySel = CI_ONE; ctrl.flagMask = MASK_ALL; end
      OP_DADD: begin ctrl.resSel = RS_DEC; ctrl.rule = CV_DEC; ctrl.carrySel = CI_FLAG;
                     ctrl.flagMask = MASK_NZC; ctrl.wrEn = 1'b1; end
      OP_AND:  begin ctrl.resSel = RS_AND; ctrl.rule = CV_LOGIC;
                     ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_BIT:  begin ctrl.resSel = RS_AND; ctrl.rule = CV_LOGIC; ctrl.flagMask = MASK_ALL; end
      OP_BIC:  begin ctrl.resSel = RS_BIC; ctrl.wrEn = 1'b1; end
      OP_BIS:  begin ctrl.resSel = RS_BIS; ctrl.wrEn = 1'b1; end
      OP_XOR:  begin ctrl.resSel = RS_XOR; ctrl.rule = CV_XOR;
                     ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_RRC:  begin ctrl.resSel = RS_SHR; ctrl.rule = CV_SHIFT; ctrl.fill = FILL_CARRY;
                     ctrl.carrySel = CI_FLAG; ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_RRU:  begin ctrl.resSel = RS_SHR; ctrl.rule = CV_SHIFT; ctrl.fill = FILL_ZERO;
                     ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_RRA:  begin ctrl.resSel = RS_SHR; ctrl.rule = CV_SHIFT; ctrl.fill = FILL_SIGN;
                     ctrl.flagMask = MASK_ALL; ctrl.wrEn = 1'b1; end
      OP_SWAP: begin ctrl.resSel = RS_SWAP; ctrl.wrEn = 1'b1; end
      OP_SEXT: begin ctrl.resSel = RS_SEXT; ctrl.wrEn = 1'b1; end
      default: ;
    endcase
  end

  always_comb begin
    unique case (condSel)
      3'd0: condTrue = !flagsIn[FLG_Z];
      3'd1: condTrue = flagsIn[FLG_Z];
      3'd2: condTrue = !flagsIn[FLG_C];
      3'd3: condTrue = flagsIn[FLG_C];
      3'd4: condTrue = flagsIn[FLG_N];
      3'd5: condTrue = (flagsIn[FLG_N] == flagsIn[FLG_V]);
      3'd6: condTrue = (flagsIn[FLG_N] != flagsIn[FLG_V]);
      default: condTrue = 1'b1;
    endcase
  end
endmodule

// File: rtl/flag_alu_dp.sv
module flag_alu_dp
  import flag_alu_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              wordMode,
  input  logic [DW-1:0]     opA,
  input  logic [DW-1:0]     opB,
  input  logic [FLAG_W-1:0] flagsIn,
  input  aluCtrl_t          ctrl,
  output logic [DW-1:0]     result,
  output logic [FLAG_W-1:0] flagsOut
);
  localparam int HALF   = DW / 2;
  localparam int DIGITS = DW / 4;

  function automatic logic [31:0] decLimit(input int nDig);
    logic [31:0] lim = 32'd1;
    for (int i = 0; i < nDig; i++) lim = lim * 32'd10;
    return lim - 32'd1;
  endfunction

  localparam logic [31:0] WORD_LIM = decLimit(DIGITS);
  localparam logic [31:0] BYTE_LIM = decLimit(DIGITS / 2);

  function automatic logic [31:0] bcdToBin(input logic [DW-1:0] v);
    logic [31:0] acc = '0;
    logic [31:0] wgt = 32'd1;
    for (int i = 0; i < DIGITS; i++) begin
      acc = acc + 32'(v[4*i +: 4]) * wgt;
      wgt = wgt * 32'd10;
    end
    return acc;
  endfunction

  function automatic logic [DW-1:0] binToBcd(input logic [31:0] v);
    logic [DW-1:0] o = '0;
    logic [31:0] wgt = 32'd1;
    for (int i = 0; i < DIGITS; i++) begin
      o[4*i +: 4] = 4'((v / wgt) % 32'd10);
      wgt = wgt * 32'd10;
    end
    return o;
  endfunction

  logic [DW-1:0] widthMask, aM, bM, bEff, rawRes;
  logic [DW:0]   addSum;
  logic [31:0]   decSum;
  logic          carryIn, addCarry, addOvf, decCarry, fillBit;
  logic          signA, signB, signSum, signRes;
  logic [DW-1:0] shr, fillVec;
  logic [FLAG_W-1:0] cand;

  assign widthMask = wordMode ? {DW{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign aM   = opA & widthMask;
  assign bM   = opB & widthMask;
  assign bEff = ctrl.invB ? (~opB & widthMask) : bM;

  always_comb begin
    unique case (ctrl.carrySel)
      CI_ONE:  carryIn = 1'b1;
      CI_FLAG: carryIn = flagsIn[FLG_C];
      default: carryIn = 1'b0;
    endcase
  end

  // shared adder: add, subtract and compare
  assign addSum   = {1'b0, aM} + {1'b0, bEff} + {{DW{1'b0}}, carryIn};
  assign addCarry = wordMode ? addSum[DW] : addSum[HALF];
  assign signA    = wordMode ? aM[DW-1]   : aM[HALF-1];
  assign signB    = wordMode ? bEff[DW-1] : bEff[HALF-1];
  assign signSum  = wordMode ? addSum[DW-1] : addSum[HALF-1];
  assign addOvf   = (signA == signB) && (signSum != signA);

  // decimal path
  assign decSum   = bcdToBin(aM) + bcdToBin(bM) + 32'(carryIn);
  assign decCarry = decSum > (wordMode ? WORD_LIM : BYTE_LIM);

  // right shift with selectable fill
  always_comb begin
    unique case (ctrl.fill)
      FILL_CARRY: fillBit = carryIn;
      FILL_SIGN:  fillBit = signA;
      default:    fillBit = 1'b0;
    endcase
    fillVec = '0;
    if (wordMode) fillVec[DW-1]   = fillBit;
    else          fillVec[HALF-1] = fillBit;
    shr = (aM >> 1) | fillVec;
  end

  always_comb begin
    unique case (ctrl.resSel)
      RS_ADD:  rawRes = addSum[DW-1:0];
      RS_DEC:  rawRes = binToBcd(decSum);
      RS_AND:  rawRes = aM & bM;
      RS_BIC:  rawRes = aM & ~bM;
      RS_BIS:  rawRes = aM | bM;
      RS_XOR:  rawRes = aM ^ bM;
      RS_SHR:  rawRes = shr;
      RS_PASS: rawRes = bM;
      RS_SWAP: rawRes = {aM[HALF-1:0], aM[DW-1:HALF]};
      RS_SEXT: rawRes = {{HALF{aM[HALF-1]}}, aM[HALF-1:0]};
      default: rawRes = '0;
    endcase
  end

  assign result  = rawRes & widthMask;
  assign signRes = wordMode ? result[DW-1] : result[HALF-1];

  always_comb begin
    cand[FLG_N] = signRes;
    cand[FLG_Z] = (result == '0);
    unique case (ctrl.rule)
      CV_ARITH: begin cand[FLG_C] = addCarry;       cand[FLG_V] = addOvf; end
      CV_DEC:   begin cand[FLG_C] = decCarry;       cand[FLG_V] = 1'b0; end
      CV_XOR:   begin cand[FLG_C] = (result != '0); cand[FLG_V] = signA & (wordMode ? bM[DW-1] : bM[HALF-1]); end
      CV_SHIFT: begin cand[FLG_C] = aM[0];          cand[FLG_V] = 1'b0; end
      default:  begin cand[FLG_C] = (result != '0); cand[FLG_V] = 1'b0; end
    endcase
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_merge
    assign flagsOut[i] = ctrl.flagMask[i] ? cand[i] : flagsIn[i];
  end
endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
(
  input  logic              wordMode,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [COND_W-1:0] condSel,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              writeResult,
  output logic              condTrue
);
  aluCtrl_t ctrl;

  flag_alu_ctrl u_ctrl (
    .opSel(opSel), .condSel(condSel), .flagsIn(flagsIn),
    .ctrl(ctrl), .condTrue(condTrue)
  );

  flag_alu_dp #(.DW(DATA_W)) u_dp (
    .wordMode(wordMode), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .ctrl(ctrl), .result(result), .flagsOut(flagsOut)
  );

  assign writeResult = ctrl.wrEn;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk
  import flag_alu_pkg::*;
(
  input logic              wordMode,
  input logic [OP_W-1:0]   opSel,
  input logic [FLAG_W-1:0] flagsIn,
  input logic [COND_W-1:0] condSel,
  input logic [DATA_W-1:0] result,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              writeResult,
  input logic              condTrue
);
  logic holdOp, noWrOp, arithOp;
  assign holdOp  = (opSel == OP_MOV) || (opSel == OP_BIC) || (opSel == OP_BIS) ||
                   (opSel == OP_SWAP) || (opSel == OP_SEXT) || (opSel > OP_SEXT);
  assign noWrOp  = (opSel == OP_CMP) || (opSel == OP_BIT) || (opSel > OP_SEXT);
  assign arithOp = (opSel >= OP_ADD) && (opSel <= OP_CMP);

  always_comb begin
    AST_BYTE_UPPER_CLEAR: assert (wordMode || result[DATA_W-1:DATA_W/2] == '0); // R1
    AST_ARITH_ZERO_FLAG: assert (!arithOp || flagsOut[FLG_Z] == (result == '0)); // R5
    AST_FLAGS_HELD: assert (!holdOp || flagsOut == flagsIn); // R9
    AST_NO_WRITE: assert (!noWrOp || !writeResult); // R10
    AST_JUMP_ALWAYS: assert (condSel != 3'd7 || condTrue); // R11
    AST_JUMP_EQ: assert (condSel != 3'd1 || condTrue == flagsIn[FLG_Z]); // R11
  end
endmodule

bind flag_alu flag_alu_chk u_chk (
  .wordMode(wordMode), .opSel(opSel), .flagsIn(flagsIn), .condSel(condSel),
  .result(result), .flagsOut(flagsOut), .writeResult(writeResult), .condTrue(condTrue)
);

// File: tb/flag_alu_tb.sv
`timescale 1ns/1ps
module flag_alu_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;
  logic rstN = 1'b0;

  logic        wordMode = 1'b0;
  logic [4:0]  opSel = 5'd0;
  logic [15:0] opA = '0, opB = '0;
  logic [3:0]  flagsIn = '0;
  logic [2:0]  condSel = '0;
  logic [15:0] result;
  logic [3:0]  flagsOut;
  logic        writeResult, condTrue;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  flag_alu u_dut (
    .wordMode(wordMode), .opSel(opSel), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .condSel(condSel), .result(result), .flagsOut(flagsOut),
    .writeResult(writeResult), .condTrue(condTrue)
  );

  function automatic int bcdVal(int v);
    return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
  endfunction
  function automatic int toBcd(int v);
    return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
  endfunction

  function automatic string reqTag(int op);
    case (op)
      1, 2:       return "R2 R4 R5";
      3, 4:       return "R3 R4 R5";
      5:          return "R3 R4 R10";
      6:          return "R6";
      7, 8, 11:   return "R7";
      12, 13, 14: return "R8";
      0, 9, 10, 15, 16: return "R9";
      default:    return "R10";
    endcase
  endfunction

  // expected values from the requirements
  task automatic model(input bit w, input int op, input int a, input int b, input bit [3:0] fi,
                       output int r, output bit [3:0] fo, output bit wr);
    int width = w ? 16 : 8;
    int mask = (1 << width) - 1;
    int top = 1 << (width - 1);
    int am = a & mask, bm = b & mask;
    int sa = (am & top) ? am - (1 << width) : am;
    int sb = (bm & top) ? bm - (1 << width) : bm;
    int cin = fi[0];
    int u, s, k;
    bit cf = 0, vf = 0, upd = 1, updV = 1;
    r = 0; fo = fi; wr = 1;
    case (op)
      0:  begin r = bm; upd = 0; end
      1, 2: begin k = (op == 2) ? cin : 0; u = am + bm + k; s = sa + sb + k;
                  r = u & mask; cf = u > mask; vf = (s > top - 1) || (s < -top); end
      3, 4, 5: begin k = (op == 4) ? cin : 1; u = am + (~bm & mask) + k; s = sa - sb + k - 1;
                  r = u & mask; cf = u > mask; vf = (s > top - 1) || (s < -top); wr = (op != 5); end
      6:  begin u = bcdVal(am) + bcdVal(bm) + cin; r = toBcd(u) & mask;
                cf = u > (w ? 9999 : 99); updV = 0; end
      7, 8: begin r = am & bm; cf = r != 0; wr = (op == 7); end
      9:  begin r = am & ~bm & mask; upd = 0; end
      10: begin r = am | bm; upd = 0; end
      11: begin r = am ^ bm; cf = r != 0; vf = ((am & top) != 0) && ((bm & top) != 0); end
      12: begin r = (am >> 1) | (cin ? top : 0); cf = am & 1; end
      13: begin r = am >> 1; cf = am & 1; end
      14: begin r = (am >> 1) | (am & top); cf = am & 1; end
      15: begin r = (((am >> 8) & 255) | ((am << 8) & 16'hff00)) & mask; upd = 0; end
      16: begin r = ((am & 128) ? (am | 16'hff00) : (am & 255)) & mask; upd = 0; end
      default: begin upd = 0; wr = 0; end
    endcase
    if (upd) begin
      fo[0] = cf; fo[1] = (r == 0); fo[2] = (r & top) != 0;
      if (updV) fo[3] = vf;
    end
  endtask

  task automatic runVec(input bit w, input int op, input int a, input int b, input bit [3:0] fi);
    int er; bit [3:0] ef; bit ew;
    @(posedge clk);
    wordMode = w; opSel = 5'(op); opA = 16'(a); opB = 16'(b); flagsIn = fi;
    @(negedge clk);
    model(w, op, a, b, fi, er, ef, ew);
    nChecks++;
    if (result !== 16'(er) || flagsOut !== ef || writeResult !== ew) begin
      nFails++;
      $display("FAIL %s op=%0d w=%0b a=%h b=%h fi=%b: got res=%h fl=%b wr=%b exp res=%h fl=%b wr=%b",
               reqTag(op), op, w, a[15:0], b[15:0], fi, result, flagsOut, writeResult,
               er[15:0], ef, ew);
    end
    if (!w) begin
      nChecks++;
      if (result[15:8] !== 8'h00) begin
        nFails++;
        $display("FAIL R1 byte upper: got %h exp 00", result[15:8]);
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int byteB[16] = '{0, 1, 2, 'h0F, 'h10, 'h3F, 'h40, 'h55, 'h7F, 'h80, 'h81, 'h99, 'hAA, 'hC3, 'hFE, 'hFF};
    int wordV[8] = '{0, 1, 'h7FFF, 'h8000, 'hFFFF, 'h1234, 'h9999, 'h00FF};
    logic [31:0] lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // quiet state: move of zero in byte mode
    @(negedge clk);
    nChecks++;
    if (result !== 16'h0 || flagsOut !== 4'h0 || writeResult !== 1'b1) begin
      nFails++;
      $display("FAIL R9 idle: got res=%h fl=%b wr=%b exp res=0000 fl=0000 wr=1", result, flagsOut, writeResult);
    end
    // byte sweep over all codes, including reserved ones (R10)
    for (int op = 0; op < 19; op++)
      for (int a = 0; a < 256; a += 3)
        for (int bi = 0; bi < 16; bi++)
          for (int c = 0; c < 2; c++)
            runVec(1'b0, op, a | ('hA5 << 8), byteB[bi], {2'b10, 1'b0, c[0]});
    // word corners (R2 R3 R4 R6 carry and overflow at bit 15)
    for (int op = 0; op < 17; op++)
      for (int ai = 0; ai < 8; ai++)
        for (int bi = 0; bi < 8; bi++)
          for (int c = 0; c < 2; c++)
            runVec(1'b1, op, wordV[ai], wordV[bi], {3'b010, c[0]});
    // pseudo-random words
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      runVec(lfsr[31], int'(lfsr[4:0]) % 20, int'(lfsr[30:15]), int'({lfsr[14:0], lfsr[31]}), lfsr[8:5]);
    end
    // branch conditions R11
    for (int cs = 0; cs < 8; cs++)
      for (int f = 0; f < 16; f++) begin
        bit e;
        @(posedge clk);
        condSel = 3'(cs); flagsIn = 4'(f);
        @(negedge clk);
        case (cs)
          0: e = !f[1]; 1: e = f[1]; 2: e = !f[0]; 3: e = f[0];
          4: e = f[2]; 5: e = (f[2] == f[3]); 6: e = (f[2] != f[3]); default: e = 1;
        endcase
        nChecks++;
        if (condTrue !== e) begin
          nFails++;
          $display("FAIL R11 cond=%0d flags=%b: got %b exp %b", cs, f[3:0], condTrue, e);
        end
      end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule